// File: doc/BRIEF.md
# Channel Status Block Capture

This block sits behind a biphase-mark receiver and gathers the channel status bit carried in every decoded subframe. The receiver presents one strobe per subframe together with the status bit, a flag telling whether the subframe is the first of its frame, and a flag that marks the first frame of a 192-frame status block. Only the first-subframe bits are gathered. Once a whole block has arrived, the leading 32 bits are copied in one step into a buffer that a host can read. A one-cycle done strobe marks that copy.

Bit 0 of each completed block drives a consumer/professional indication. In professional mode an 8-bit CRC, computed over the first 184 bits, is compared with the final byte of the block, and a mismatch is flagged. A block-start flag that arrives in the middle of a block discards the partial block and pulses a framing error. Bits that arrive while the block is not aligned are dropped.

Top module: `cs_block_capture`

## Requirements
- R1: Only strobes with the first-subframe flag set supply status bits. Second-subframe strobes change nothing, even when they carry a different bit.
- R2: Bit gathering begins only at a first-subframe strobe that has the block-start flag set. Strobes that arrive before any start, or after a completed block and before the next start, are ignored.
- R3: When the 192nd bit of a block is taken, the buffer is loaded with block bits 0..31, bit i going to `cs_buf_o[i]`. The buffer holds that value until the next block completes.
- R4: `pro_mode_o` equals bit 0 of the last completed block (0 for consumer, 1 for professional).
- R5: `blk_done_o` is high for exactly one cycle, the cycle after the edge at which the 192nd bit was taken.
- R6: At block completion, `crc_err_o` is set when bit 0 is 1 and the CRC differs from the received byte (block bits 184..191, with bit 184 as the LSB). The CRC uses x^8+x^4+x^3+x^2+1 with preset 0xFF and is fed bits 0..183 in arrival order, MSB-first shift. In consumer mode `crc_err_o` is 0. The value holds until the next completion.
- R7: A start flag that arrives while a block is partly gathered pulses `frame_err_o` for one cycle and restarts the block from that bit. The buffer, the mode output and the CRC flag do not change.
- R8: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sf_valid_i | input | 1 | One-cycle strobe per decoded subframe |
| sf_cbit_i | input | 1 | Channel status bit of the subframe |
| sf_first_i | input | 1 | 1 for the first subframe of a frame |
| sf_blk_start_i | input | 1 | Marks the first frame of a status block |
| cs_buf_o | output | 32 | Leading status bits of the last completed block |
| pro_mode_o | output | 1 | Bit 0 of the last completed block |
| blk_done_o | output | 1 | One-cycle pulse on block completion |
| crc_err_o | output | 1 | Professional-mode CRC mismatch |
| frame_err_o | output | 1 | One-cycle pulse when a partial block is aborted |

## Verification
The bench builds the block with its default parameters: a 192-bit block, a 32-bit buffer and an 8-bit CRC. Only at these values does the CRC tail fall on byte 23, so good and bad CRC bytes can be written into professional blocks. The 192-bit block is short enough that several full blocks fit in one run. They are sent back to back, with an aborted partial block between them, with stray bits before the first start and after a completed block, and with the second-subframe bit always the opposite of the first-subframe bit.

// File: rtl/cs_pkg.sv
package cs_pkg;
    parameter int unsigned CS_CRC_W = 8;
    parameter logic [CS_CRC_W-1:0] CS_CRC_POLY = 8'h1D;
    parameter logic [CS_CRC_W-1:0] CS_CRC_INIT = 8'hFF;
    typedef logic [CS_CRC_W-1:0] cs_crc_t;
endpackage

// File: rtl/cs_crc_step.sv
module cs_crc_step #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] POLY = '1
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end
endmodule

// File: rtl/cs_lead_capture.sv
module cs_lead_capture #(
    parameter int unsigned NBITS = 32,
    parameter int unsigned IDX_W = 8
) (
    input  logic [NBITS-1:0] stage_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             bit_i,
    input  logic             we_i,
    output logic [NBITS-1:0] stage_o
);
    for (genvar g = 0; g < NBITS; g++) begin : g_slot
        assign stage_o[g] = (we_i && idx_i == IDX_W'(g)) ? bit_i : stage_i[g];
    end
endmodule

// File: rtl/cs_block_capture.sv
module cs_block_capture
    import cs_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 192,
    parameter int unsigned BUF_BITS  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sf_valid_i,
    input  logic                sf_cbit_i,
    input  logic                sf_first_i,
    input  logic                sf_blk_start_i,
    output logic [BUF_BITS-1:0] cs_buf_o,
    output logic                pro_mode_o,
    output logic                blk_done_o,
    output logic                crc_err_o,
    output logic                frame_err_o
);
    localparam int unsigned IDX_W = $clog2(BLOCK_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);
    localparam logic [IDX_W-1:0] TAIL_IDX = IDX_W'(BLOCK_LEN - CS_CRC_W);
    localparam logic [IDX_W-1:0] BUF_END  = IDX_W'(BUF_BITS);

    typedef struct packed {
        logic                active;
        logic [IDX_W-1:0]    cnt;
        logic [BUF_BITS-1:0] stage;
        cs_crc_t             crc;
        cs_crc_t             tail;
        logic [BUF_BITS-1:0] buf_v;
        logic                pro;
        logic                done;
        logic                crc_err;
        logic                frame_err;
    } state_t;

    state_t st_d, st_q;

    logic             take, accept;
    logic [IDX_W-1:0] idx;
    cs_crc_t          crc_in, crc_nx;
    logic [BUF_BITS-1:0] stage_nx;

    always_comb begin
        take   = sf_valid_i && sf_first_i;
        accept = take && (sf_blk_start_i || st_q.active);
        idx    = sf_blk_start_i ? '0 : st_q.cnt;
        crc_in = sf_blk_start_i ? CS_CRC_INIT : st_q.crc;
    end

    cs_crc_step #(.W(CS_CRC_W), .POLY(CS_CRC_POLY)) i_crc (
        .crc_i(crc_in), .bit_i(sf_cbit_i), .crc_o(crc_nx)
    );

    cs_lead_capture #(.NBITS(BUF_BITS), .IDX_W(IDX_W)) i_lead (
        .stage_i(st_q.stage), .idx_i(idx), .bit_i(sf_cbit_i),
        .we_i(accept && idx < BUF_END), .stage_o(stage_nx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.frame_err = 1'b0;
        if (take && sf_blk_start_i && st_q.active) begin
            st_d.frame_err = 1'b1;
        end
        if (accept) begin
            st_d.stage = stage_nx;
            st_d.crc   = (idx < TAIL_IDX) ? crc_nx : crc_in;
            if (idx >= TAIL_IDX) begin
                st_d.tail = {sf_cbit_i, st_q.tail[CS_CRC_W-1:1]};
            end
            if (idx == LAST_IDX) begin
                st_d.active  = 1'b0;
                st_d.cnt     = '0;
                st_d.done    = 1'b1;
                st_d.buf_v   = stage_nx;
                st_d.pro     = stage_nx[0];
                st_d.crc_err = stage_nx[0] && (st_d.tail != crc_in);
            end else begin
                st_d.active = 1'b1;
                st_d.cnt    = idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_buf_o    = st_q.buf_v;
    assign pro_mode_o  = st_q.pro;
    assign blk_done_o  = st_q.done;
    assign crc_err_o   = st_q.crc_err;
    assign frame_err_o = st_q.frame_err;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |=> !blk_done_o);
    // R3
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_done_o |-> $stable(cs_buf_o));
    // R4
    mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> (pro_mode_o == cs_buf_o[0]));
    // R6
    crc_consumer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pro_mode_o |-> !crc_err_o);
    // R7
    abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (!blk_done_o && $stable(cs_buf_o)));
    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (st_q.cnt == '0));
endmodule

// File: tb/test_cs_block_capture.sv
module test_cs_block_capture;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sf_valid = 1'b0, sf_cbit = 1'b0, sf_first = 1'b0, sf_start = 1'b0;
    logic [31:0] cs_buf;
    logic pro_mode, blk_done, crc_err, frame_err;

    always #2.5 clk = ~clk;

    cs_block_capture i_cs_block_capture (
        .clk(clk), .rst_n(rst_n), .sf_valid_i(sf_valid), .sf_cbit_i(sf_cbit),
        .sf_first_i(sf_first), .sf_blk_start_i(sf_start), .cs_buf_o(cs_buf),
        .pro_mode_o(pro_mode), .blk_done_o(blk_done), .crc_err_o(crc_err),
        .frame_err_o(frame_err)
    );

    int total = 0, bad = 0, done_seen = 0, ferr_seen = 0;
    bit finished = 0, cmp_on = 0;

    // behavioural reference
    bit mq[$];
    bit m_active = 0;
    logic [31:0] e_buf = '0;
    bit e_pro = 0, e_done = 0, e_crc = 0, e_ferr = 0;

    function automatic logic [7:0] ref_crc(input bit b[$]);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < 184; i++) begin
            bit fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_active = 0; e_buf = '0;
            e_pro = 0; e_done = 0; e_crc = 0; e_ferr = 0;
        end else begin
            e_done = 0; e_ferr = 0;
            if (sf_valid && sf_first) begin
                if (sf_start) begin
                    if (m_active) e_ferr = 1;
                    mq.delete(); m_active = 1;
                end
                if (m_active) begin
                    mq.push_back(sf_cbit);
                    if (mq.size() == 192) begin
                        logic [7:0] rx = '0;
                        for (int i = 0; i < 32; i++) e_buf[i] = mq[i];
                        for (int i = 0; i < 8; i++) rx[i] = mq[184 + i];
                        e_pro = mq[0];
                        e_crc = mq[0] && (ref_crc(mq) != rx);
                        e_done = 1;
                        mq.delete(); m_active = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(cs_buf == e_buf, "R3 buffer", cs_buf, e_buf);
            check(pro_mode == e_pro, "R4 mode", pro_mode, e_pro);
            check(blk_done == e_done, "R5 done", blk_done, e_done);
            check(crc_err == e_crc, "R6 crc", crc_err, e_crc);
            check(frame_err == e_ferr, "R7 frame", frame_err, e_ferr);
            if (blk_done) done_seen++;
            if (frame_err) ferr_seen++;
        end
    end

    function automatic logic [191:0] mk_block(input bit pro, input int seed, input bit good);
        logic [191:0] b;
        bit q[$];
        logic [7:0] c;
        for (int i = 0; i < 192; i++) b[i] = ((i * seed + (i >> 2) * 3 + seed) % 7) > 3;
        b[0] = pro;
        for (int i = 0; i < 184; i++) q.push_back(b[i]);
        c = ref_crc(q);
        if (!good) c = c ^ 8'h5A;
        b[191:184] = c;
        return b;
    endfunction

    task automatic frame(input bit c, input bit start, input bit gap);
        sf_valid = 1; sf_first = 1; sf_cbit = c; sf_start = start;
        @(negedge clk);
        // R1: second subframe always carries the opposite bit
        sf_first = 0; sf_cbit = ~c; sf_start = 0;
        @(negedge clk);
        sf_valid = 0;
        if (gap) @(negedge clk);
    endtask

    task automatic send(input logic [191:0] b, input int n, input bit start);
        for (int i = 0; i < n; i++) frame(b[i], start && i == 0, (i % 5) == 3);
    endtask

    logic [191:0] ba, bb, bc, bd, be, bf;

    initial begin
        #500us;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ba = mk_block(0, 5, 0);
        bb = mk_block(1, 11, 1);
        bc = mk_block(1, 13, 0);
        bd = mk_block(1, 17, 1);
        be = mk_block(1, 19, 1);
        bf = mk_block(0, 23, 1);
        repeat (3) @(negedge clk);
        // R8 reset state
        check(cs_buf == 0 && !pro_mode && !blk_done && !crc_err && !frame_err,
              "R8 reset outputs", {cs_buf, pro_mode, blk_done, crc_err, frame_err}, 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        // R2: bits before any start are dropped
        send(bd, 20, 0);
        check(cs_buf == 0 && done_seen == 0, "R2 stray before start", cs_buf, 0);
        // consumer block with a wrong CRC byte
        send(ba, 192, 1);
        repeat (2) @(negedge clk);
        check(cs_buf == ba[31:0], "R1 left bits only", cs_buf, ba[31:0]);
        check(crc_err == 0, "R6 consumer ignores crc", crc_err, 0);
        check(pro_mode == 0, "R4 consumer", pro_mode, 0);
        send(bb, 192, 1);
        @(negedge clk);
        check(pro_mode == 1 && crc_err == 0, "R6 good pro crc", {pro_mode, crc_err}, 2'b10);
        send(bc, 192, 1);
        @(negedge clk);
        check(crc_err == 1, "R6 bad pro crc", crc_err, 1);
        // R7: abort partway, then a full block
        send(bd, 100, 1);
        check(cs_buf == bc[31:0], "R7 buffer kept during partial", cs_buf, bc[31:0]);
        send(be, 192, 1);
        @(negedge clk);
        check(ferr_seen == 1, "R7 one abort pulse", ferr_seen, 1);
        check(cs_buf == be[31:0] && crc_err == 0, "R7 restart block", cs_buf, be[31:0]);
        // R2: bits after completion without a new start
        send(ba, 30, 0);
        check(done_seen == 4 && cs_buf == be[31:0], "R2 stray after block", done_seen, 4);
        send(bf, 192, 1);
        @(negedge clk);
        check(done_seen == 5, "R5 done count", done_seen, 5);
        check(cs_buf == bf[31:0] && !pro_mode, "R3 final buffer", cs_buf, bf[31:0]);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule